// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of primary sources and a wider secondary group, and reduces them to one request line for the processor. There are 26 primary lines. Lines 0 to 15 are held in a low status word and lines 16 to 25 in bits 0 to 9 of a high status word. Each word has its own enable mask. The 32 secondary lines have their own status and mask words. The secondary group's masked summary is brought out as a port and is also ORed into one designated primary line, so a secondary event reaches the processor through the primary masks.

Software reaches the block through a simple register port with byte offsets. A status word is acknowledged by writing ones to the bits to be dropped. Masks are loaded directly. Both outputs are functions of the registered state, so they follow every register access and every line change one clock edge later. Priority selection and vector generation belong elsewhere.

Top module: `intc_cascade_top`

## Requirements
- R1: After reset every status and mask register reads 0, and `cpu_irq_o` and `sec_irq_o` are low.
- R2: Primary line k with k < 16 is recorded in bit k of the low status word (offset 0x80). Line k with 16 <= k < 26 is recorded in bit k-16 of the high status word (offset 0xA0). Bits 10 to 15 of the high word always read 0.
- R3: A read (`bus_en_i`=1, `bus_we_i`=0) returns the value on `bus_rdata_o` in the same cycle, zero-extended to 32 bits. The offsets are: low status 0x80, low mask 0x8C, high status 0xA0, high mask 0xA6, secondary status 0x88 with an identical copy at 0x108, and secondary mask 0x94. Any other offset reads 0, and `bus_rdata_o` is 0 whenever no read is in progress.
- R4: Writing a status offset clears each status bit whose data bit is 1, provided that bit's line was already high in the previous cycle. Data bits above the word width have no effect. Writing 0x108 acts exactly like writing 0x88.
- R5: A write to a mask offset loads the data directly. For the two primary masks only the low 16 data bits are kept. The secondary mask keeps all 32 bits.
- R6: `cpu_irq_o` is high exactly when (low status AND low mask) OR (high status AND high mask) is nonzero, evaluated on the registers. It therefore reflects a write in the cycle after that write's clock edge.
- R7: `sec_irq_o` is high exactly when (secondary status AND secondary mask) is nonzero. It is ORed into primary line CASCADE_LINE (default 8), which reaches the low status word one edge later.
- R8: A line that is low at a clock edge has its status bit cleared at that edge.
- R9: A line that is low in one cycle and high in the next sets its status bit at that edge. A line held high after its bit was cleared by a write stays clear until the line falls and rises again.
- R10: When a rising line and a status write that clears the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_line_i | input | 26 | Primary request levels |
| sec_line_i | input | 32 | Secondary group request levels |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| cpu_irq_o | output | 1 | Request to the processor |
| sec_irq_o | output | 1 | Masked summary of the secondary group |

## Verification
The bench aims at the race between a clearing write and a rising line on the same bit. A design that let the write win would lose an edge, and the status would read clear while the source waits. It holds a line high across an acknowledge to confirm that the bit does not come back on its own; a purely level-following status would re-assert it every cycle and produce an interrupt storm. It drives the cascade end to end, from a secondary line through the secondary mask and into the primary word and the processor output, and then clears it through the mirror offset. A wrong designated line, a mirror that is not decoded, or a missing cascade stage would each show up as a wrong primary read or an output that arrives a cycle early or late. Masks are written with junk in their upper data bits, and the high status word is read for phantom bits above line 25.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [15:0] OFS_STAT_LO  = 16'h0080;
  localparam logic [15:0] OFS_SEC_STAT = 16'h0088;
  localparam logic [15:0] OFS_MASK_LO  = 16'h008C;
  localparam logic [15:0] OFS_SEC_MASK = 16'h0094;
  localparam logic [15:0] OFS_STAT_HI  = 16'h00A0;
  localparam logic [15:0] OFS_MASK_HI  = 16'h00A6;
  localparam logic [15:0] OFS_SEC_COPY = 16'h0108;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT_LO,
    SEL_MASK_LO,
    SEL_STAT_HI,
    SEL_MASK_HI,
    SEL_SEC_STAT,
    SEL_SEC_MASK
  } reg_sel_e;

  // Map a byte offset onto a register selector; unknown offsets select nothing.
  function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
    reg_sel_e sel;
    unique case (ofs)
      OFS_STAT_LO:               sel = SEL_STAT_LO;
      OFS_MASK_LO:               sel = SEL_MASK_LO;
      OFS_STAT_HI:               sel = SEL_STAT_HI;
      OFS_MASK_HI:               sel = SEL_MASK_HI;
      OFS_SEC_STAT, OFS_SEC_COPY: sel = SEL_SEC_STAT;
      OFS_SEC_MASK:              sel = SEL_SEC_MASK;
      default:                   sel = SEL_NONE;
    endcase
    return sel;
  endfunction

  // True when any pending bit is also enabled.
  function automatic logic any_enabled(input logic [31:0] pend, input logic [31:0] ena);
    return |(pend & ena);
  endfunction

  // Next status: a rising line sets, a low line clears, a write clears steady-high bits.
  function automatic logic [31:0] next_status(input logic [31:0] cur,
                                              input logic [31:0] rise,
                                              input logic [31:0] low,
                                              input logic [31:0] wclr);
    return (cur & ~low & ~wclr) | rise;
  endfunction

endpackage

// File: rtl/intc_status_bank.sv
module intc_status_bank
  import intc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  input  logic             wclr_en_i,
  input  logic [WIDTH-1:0] wclr_i,
  output logic [WIDTH-1:0] stat_o
);

  logic [WIDTH-1:0] stat_q;
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise_w;
  logic [WIDTH-1:0] low_w;
  logic [WIDTH-1:0] clr_w;
  logic [31:0]      next_w;

  assign rise_w = line_i & ~prev_q;
  assign low_w  = ~line_i;
  assign clr_w  = wclr_en_i ? wclr_i : '0;
  assign next_w = next_status(32'(stat_q), 32'(rise_w), 32'(low_w), 32'(clr_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= next_w[WIDTH-1:0];
      prev_q <= line_i;
    end
  end

  assign stat_o = stat_q;

  // R9: a fresh rising edge always lands in the status register
  p_rise_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((stat_q & $past(rise_w)) == $past(rise_w)));

  // R8: a line that was low leaves no status bit behind
  p_low_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_w != '0) |=> ((stat_q & $past(low_w)) == '0));

  // R10: rising edge beats a same-cycle clearing write
  p_rise_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr_en_i && ((wclr_i & rise_w) != '0))
      |=> ((stat_q & $past(wclr_i & rise_w)) == $past(wclr_i & rise_w)));

  // R4: written ones drop every bit that did not just rise
  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wclr_en_i |=> ((stat_q & $past(wclr_i & ~rise_w)) == '0));

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [STAT_W-1:0] stat_lo_i,
  input  logic [STAT_W-1:0] stat_hi_i,
  input  logic [SEC_W-1:0]  sec_stat_i,
  output logic [STAT_W-1:0] mask_lo_o,
  output logic [STAT_W-1:0] mask_hi_o,
  output logic [SEC_W-1:0]  sec_mask_o,
  output logic              clr_lo_o,
  output logic              clr_hi_o,
  output logic              clr_sec_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e          sel_w;
  logic              wr_w;
  logic              rd_w;
  logic [STAT_W-1:0] mask_lo_q;
  logic [STAT_W-1:0] mask_hi_q;
  logic [SEC_W-1:0]  sec_mask_q;

  assign sel_w = decode_offset(16'(bus_addr_i));
  assign wr_w  = bus_en_i & bus_we_i;
  assign rd_w  = bus_en_i & ~bus_we_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo_q  <= '0;
      mask_hi_q  <= '0;
      sec_mask_q <= '0;
    end else if (wr_w) begin
      if (sel_w == SEL_MASK_LO)  mask_lo_q  <= bus_wdata_i[STAT_W-1:0];
      if (sel_w == SEL_MASK_HI)  mask_hi_q  <= bus_wdata_i[STAT_W-1:0];
      if (sel_w == SEL_SEC_MASK) sec_mask_q <= bus_wdata_i[SEC_W-1:0];
    end
  end

  assign clr_lo_o  = wr_w && (sel_w == SEL_STAT_LO);
  assign clr_hi_o  = wr_w && (sel_w == SEL_STAT_HI);
  assign clr_sec_o = wr_w && (sel_w == SEL_SEC_STAT);

  assign mask_lo_o  = mask_lo_q;
  assign mask_hi_o  = mask_hi_q;
  assign sec_mask_o = sec_mask_q;

  always_comb begin
    rdata_o = '0;
    if (rd_w) begin
      unique case (sel_w)
        SEL_STAT_LO:  rdata_o[STAT_W-1:0] = stat_lo_i;
        SEL_MASK_LO:  rdata_o[STAT_W-1:0] = mask_lo_q;
        SEL_STAT_HI:  rdata_o[STAT_W-1:0] = stat_hi_i;
        SEL_MASK_HI:  rdata_o[STAT_W-1:0] = mask_hi_q;
        SEL_SEC_STAT: rdata_o[SEC_W-1:0]  = sec_stat_i;
        SEL_SEC_MASK: rdata_o[SEC_W-1:0]  = sec_mask_q;
        default:      rdata_o = '0;
      endcase
    end
  end

  // R5: low mask takes exactly the low data bits of its write
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w && (sel_w == SEL_MASK_LO)) |=> (mask_lo_q == $past(bus_wdata_i[STAT_W-1:0])));

  // R3: no read in progress means a quiet read bus
  p_idle_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_w |-> (rdata_o == '0));

endmodule

// File: rtl/intc_cascade_top.sv
module intc_cascade_top
  import intc_pkg::*;
#(
  parameter int PRI_LINES    = 26,
  parameter int SEC_LINES    = 32,
  parameter int STAT_W       = 16,
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 32,
  parameter int CASCADE_LINE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRI_LINES-1:0] pri_line_i,
  input  logic [SEC_LINES-1:0] sec_line_i,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 cpu_irq_o,
  output logic                 sec_irq_o
);

  localparam int NUM_BANKS = 2;
  localparam int WIDE_W    = NUM_BANKS * STAT_W;

  logic [PRI_LINES-1:0] pri_eff_w;
  logic [WIDE_W-1:0]    pri_wide_w;
  logic [WIDE_W-1:0]    stat_wide_w;
  logic [NUM_BANKS-1:0] clr_bank_w;
  logic [STAT_W-1:0]    mask_lo_w;
  logic [STAT_W-1:0]    mask_hi_w;
  logic [SEC_LINES-1:0] sec_stat_w;
  logic [SEC_LINES-1:0] sec_mask_w;
  logic                 clr_sec_w;
  logic                 sec_sum_w;

  // Secondary group summary and its cascade into the designated primary line
  assign sec_sum_w = any_enabled(32'(sec_stat_w), 32'(sec_mask_w));

  always_comb begin
    pri_eff_w = pri_line_i;
    pri_eff_w[CASCADE_LINE] = pri_line_i[CASCADE_LINE] | sec_sum_w;
    pri_wide_w = '0;
    pri_wide_w[PRI_LINES-1:0] = pri_eff_w;
  end

  intc_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STAT_W (STAT_W),
    .SEC_W  (SEC_LINES)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .stat_lo_i   (stat_wide_w[STAT_W-1:0]),
    .stat_hi_i   (stat_wide_w[WIDE_W-1:STAT_W]),
    .sec_stat_i  (sec_stat_w),
    .mask_lo_o   (mask_lo_w),
    .mask_hi_o   (mask_hi_w),
    .sec_mask_o  (sec_mask_w),
    .clr_lo_o    (clr_bank_w[0]),
    .clr_hi_o    (clr_bank_w[1]),
    .clr_sec_o   (clr_sec_w),
    .rdata_o     (bus_rdata_o)
  );

  // One status bank per primary word
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pri_bank
    intc_status_bank #(.WIDTH(STAT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (pri_wide_w[b*STAT_W +: STAT_W]),
      .wclr_en_i (clr_bank_w[b]),
      .wclr_i    (bus_wdata_i[STAT_W-1:0]),
      .stat_o    (stat_wide_w[b*STAT_W +: STAT_W])
    );
  end

  intc_status_bank #(.WIDTH(SEC_LINES)) u_sec_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (sec_line_i),
    .wclr_en_i (clr_sec_w),
    .wclr_i    (bus_wdata_i[SEC_LINES-1:0]),
    .stat_o    (sec_stat_w)
  );

  assign cpu_irq_o = any_enabled(32'(stat_wide_w[STAT_W-1:0]), 32'(mask_lo_w)) |
                     any_enabled(32'(stat_wide_w[WIDE_W-1:STAT_W]), 32'(mask_hi_w));
  assign sec_irq_o = sec_sum_w;

  // R6: with both primary masks clear the processor request stays low
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_lo_w == '0) && (mask_hi_w == '0)) |-> !cpu_irq_o);

  // R7: with the secondary mask clear the summary stays low
  p_sec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mask_w == '0) |-> !sec_irq_o);

  // R7: a new secondary summary reaches the designated primary status bit
  p_cascade_feed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_irq_o && !$past(pri_eff_w[CASCADE_LINE])) |=> stat_wide_w[CASCADE_LINE]);

  // R2: the high word never shows bits above the last primary line
  p_hi_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wide_w[WIDE_W-1:PRI_LINES] == '0);

endmodule

// File: tb/intc_cascade_top_tb_top.sv
`timescale 1ns/1ps
module intc_cascade_top_tb_top;

  localparam int CASC = 8;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] pri_line = '0;
  logic [31:0] sec_line = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic        sec_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  intc_cascade_top dut_i (
    .clk(clk), .rst_n(rst_n), .pri_line_i(pri_line), .sec_line_i(sec_line),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cpu_irq_o(cpu_irq), .sec_irq_o(sec_irq)
  );

  // ---------------- reference model ----------------
  bit        m_pst[26];
  bit        m_pprev[26];
  bit        m_sst[32];
  bit        m_sprev[32];
  int unsigned m_mask_lo, m_mask_hi, m_smask;

  function automatic bit m_sec_any();
    for (int i = 0; i < 32; i++) if (m_sst[i] && m_smask[i]) return 1;
    return 0;
  endfunction

  function automatic bit m_cpu_any();
    for (int i = 0; i < 16; i++) if (m_pst[i] && m_mask_lo[i]) return 1;
    for (int i = 16; i < 26; i++) if (m_pst[i] && m_mask_hi[i-16]) return 1;
    return 0;
  endfunction

  function automatic int unsigned m_read(int unsigned a);
    int unsigned v = 0;
    case (a)
      'h080: for (int i = 0; i < 16; i++) v += m_pst[i] ? (1 << i) : 0;
      'h0A0: for (int i = 16; i < 26; i++) v += m_pst[i] ? (1 << (i-16)) : 0;
      'h088, 'h108: for (int i = 0; i < 32; i++) v += m_sst[i] ? (1 << i) : 0;
      'h08C: v = m_mask_lo & 'hFFFF;
      'h0A6: v = m_mask_hi & 'hFFFF;
      'h094: v = m_smask;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin : model_step
    bit ln, wc, sum;
    bit wr;
    if (!rst_n) begin
      for (int i = 0; i < 26; i++) begin m_pst[i] = 0; m_pprev[i] = 0; end
      for (int i = 0; i < 32; i++) begin m_sst[i] = 0; m_sprev[i] = 0; end
      m_mask_lo = 0; m_mask_hi = 0; m_smask = 0;
    end else begin
      wr = bus_en && bus_we;
      sum = m_sec_any();
      for (int i = 0; i < 26; i++) begin
        ln = pri_line[i] || (i == CASC && sum);
        wc = 0;
        if (wr && i < 16 && bus_addr == 9'h080) wc = bus_wdata[i];
        if (wr && i >= 16 && bus_addr == 9'h0A0) wc = bus_wdata[i-16];
        if (ln && !m_pprev[i]) m_pst[i] = 1;
        else if (!ln) m_pst[i] = 0;
        else if (wc) m_pst[i] = 0;
        m_pprev[i] = ln;
      end
      for (int i = 0; i < 32; i++) begin
        ln = sec_line[i];
        wc = wr && (bus_addr == 9'h088 || bus_addr == 9'h108) && bus_wdata[i];
        if (ln && !m_sprev[i]) m_sst[i] = 1;
        else if (!ln) m_sst[i] = 0;
        else if (wc) m_sst[i] = 0;
        m_sprev[i] = ln;
      end
      if (wr && bus_addr == 9'h08C) m_mask_lo = bus_wdata & 'hFFFF;
      if (wr && bus_addr == 9'h0A6) m_mask_hi = bus_wdata & 'hFFFF;
      if (wr && bus_addr == 9'h094) m_smask = bus_wdata;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R6 cpu_irq vs model", {31'b0, cpu_irq}, {31'b0, m_cpu_any()});
      chk("R7 sec_irq vs model", {31'b0, sec_irq}, {31'b0, m_sec_any()});
      chk("R3 rdata vs model", bus_rdata,
          (bus_en && !bus_we) ? m_read(bus_addr) : 32'h0);
    end
  end

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
    #1 bus_en = 0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic expect_rd(string tag, logic [8:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic expect_pin(string tag, logic act, logic exp);
    #1 chk(tag, {31'b0, act}, {31'b0, exp});
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0] addrs [8];
    addrs = '{9'h080, 9'h088, 9'h08C, 9'h094, 9'h0A0, 9'h0A6, 9'h108, 9'h084};

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    expect_pin("R1 cpu_irq after reset", cpu_irq, 1'b0);
    expect_pin("R1 sec_irq after reset", sec_irq, 1'b0);
    foreach (addrs[k]) expect_rd("R1 register after reset", addrs[k], 32'h0);

    // R2: line placement
    @(negedge clk);
    pri_line = 26'h0100003;              // lines 0, 1, 20
    expect_rd("R2 low status", 9'h080, 32'h0003);
    expect_rd("R2 high status", 9'h0A0, 32'h0010);
    expect_pin("R6 masks clear keep cpu_irq low", cpu_irq, 1'b0);

    // R5/R6: mask load with junk upper bits, output the cycle after
    wr(9'h08C, 32'hFFFF_0002);
    expect_pin("R6 cpu_irq follows mask write", cpu_irq, 1'b1);
    expect_rd("R5 low mask truncated", 9'h08C, 32'h0002);

    // R4/R9: acknowledge while line held high
    wr(9'h080, 32'hABCD_0002);
    expect_pin("R6 cpu_irq drops after ack", cpu_irq, 1'b0);
    expect_rd("R4 ack clears bit 1", 9'h080, 32'h0001);
    repeat (3) @(negedge clk);
    expect_rd("R9 held line stays acknowledged", 9'h080, 32'h0001);

    // R8: falling lines clear
    @(negedge clk);
    pri_line = 26'h0100000;
    expect_rd("R8 low lines clear status", 9'h080, 32'h0000);
    // R9: new rising edge sets again
    @(negedge clk);
    pri_line = 26'h0100002;
    expect_rd("R9 re-rise sets bit 1", 9'h080, 32'h0002);
    expect_pin("R6 cpu_irq on re-rise", cpu_irq, 1'b1);

    // R10: rise and clear in the same cycle
    @(negedge clk);
    pri_line = 26'h0100022;
    bus_en = 1; bus_we = 1; bus_addr = 9'h080; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_wdata = '0;
    expect_rd("R10 rising line beats ack", 9'h080, 32'h0022);

    // R5/R6: high mask path
    wr(9'h08C, 32'h0);
    wr(9'h0A6, 32'h0000_0010);
    expect_pin("R6 cpu_irq from high word", cpu_irq, 1'b1);
    expect_rd("R5 high mask readback", 9'h0A6, 32'h0010);
    wr(9'h0A6, 32'h0);
    expect_pin("R6 cpu_irq off with high mask clear", cpu_irq, 1'b0);

    // R3: undecoded offsets
    expect_rd("R3 undecoded 0x84", 9'h084, 32'h0);
    expect_rd("R3 undecoded 0x1FE", 9'h1FE, 32'h0);

    // R4: high word acknowledge, R2 no phantom bits
    wr(9'h0A0, 32'hFFFF_FFFF);
    expect_rd("R4 high word ack", 9'h0A0, 32'h0000);

    // R3/R7: secondary group and mirror
    @(negedge clk);
    sec_line = 32'h8000_0001;
    expect_rd("R3 secondary status", 9'h088, 32'h8000_0001);
    expect_rd("R3 secondary copy", 9'h108, 32'h8000_0001);
    expect_pin("R7 summary low with mask clear", sec_irq, 1'b0);
    expect_rd("R7 no cascade yet", 9'h080, 32'h0022);

    wr(9'h094, 32'h8000_0000);
    expect_pin("R7 summary after mask write", sec_irq, 1'b1);
    expect_rd("R7 cascade reaches line 8", 9'h080, 32'h0122);
    expect_rd("R5 secondary mask readback", 9'h094, 32'h8000_0000);
    wr(9'h08C, 32'h0000_0100);
    expect_pin("R7 cascade to cpu_irq", cpu_irq, 1'b1);

    // R4/R8: ack through the copy offset, cascade falls
    wr(9'h108, 32'h8000_0000);
    expect_pin("R4 copy ack drops summary", sec_irq, 1'b0);
    expect_rd("R8 cascade line cleared", 9'h080, 32'h0022);
    expect_pin("R6 cpu_irq after cascade clears", cpu_irq, 1'b0);
    expect_rd("R4 secondary after copy ack", 9'h088, 32'h0000_0001);

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      @(negedge clk);
      r = $urandom;
      if (r[2:0] == 0) pri_line = pri_line ^ (26'd1 << ($urandom % 26));
      if (r[5:3] == 0) sec_line = sec_line ^ (32'd1 << ($urandom % 32));
      case (r[9:8])
        2'd0: begin bus_en = 0; bus_we = 0; end
        2'd1: begin bus_en = 1; bus_we = 0; bus_addr = addrs[r[12:10]]; end
        default: begin
          bus_en = 1; bus_we = 1; bus_addr = addrs[r[12:10]];
          bus_wdata = $urandom;
        end
      endcase
    end
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    @(negedge clk);

    #2;
    finished = 1;
    summary();
    $finish;
  end

endmodule